// File: doc/BRIEF.md
# ADC result and status flag tracker

This block holds the per-channel conversion results and the status flags of a multi-channel ADC controller. A conversion-complete event delivers a channel index and a result word. If that channel is enabled, the block stores the word in that channel's result slot and in a shared most-recent-result register, and it updates four kinds of flag:
- a per-channel result-pending bit;
- a per-channel lost-result bit;
- a global new-result bit;
- a global lost-result bit.

Bus reads of a channel result, of the most-recent result or of the status word clear flags as a side effect. Writes to an enable mask and to a disable mask select which channels take part.

Any read, enable write or disable write can fall in the same clock cycle as a conversion event. Every flag is computed from the flag values before that cycle, the clearing effect of the read and the setting effect of the conversion. No combination of same-cycle events loses a set or a clear that it should produce. A read always returns the contents as they were before the same-cycle update.

Top module: `adc_status_tracker`

## Requirements
- R1: After reset, all flags are 0, the most-recent-result register reads 0, `rd_ack` is 0 and every channel is disabled, so a conversion event has no effect until a channel is enabled.
- R2: An accepted conversion on channel x stores its result in channel x's slot and in the most-recent register, and it sets pending[x] and the new-result flag. `rd_sel` selects the read source: 0 is the status word, 1 is the most-recent register, 2 is a channel slot chosen by `rd_chan`. `rd_data` and `rd_ack` are valid in the cycle after `rd_valid`. The read returns the contents from before any same-cycle update. The status word holds pending in bits 7:0, lost[i] in bits 15:8, new-result in bit 16 and global-lost in bit 17. The most-recent word holds the result in bits 9:0 and its channel number in bits 14:12.
- R3: pending[i] clears on a read of channel i's slot. It also clears on a read of the most-recent register while that register holds channel i's result. No other bit is affected.
- R4: lost[x] sets when a conversion on x is accepted while pending[x] was already set, even if pending[x] is read clear in that same cycle.
- R5: global-lost sets when a conversion is accepted while new-result was already set, including when a different channel's slot is read in that same cycle.
- R6: A status read clears global-lost and every lost[i]. A conversion in the same cycle still sets pending and sets lost or global-lost if its own condition holds. When lost[x] is set and pending[x] is clear, a status read together with a conversion on x leaves lost[x] clear.
- R7: A read of the most-recent register clears new-result. A conversion accepted in the same cycle keeps it set.
- R8: Disabling channel y in the same cycle as a conversion on enabled channel x does not suppress x's storage, new-result, pending or global-lost update.
- R9: A conversion on a disabled channel, or on a channel disabled in that same cycle, is discarded: no slot or most-recent write, and no flag change. This holds even when a slot read falls in that cycle.
- R10: An enable write sets the mask bits given and a disable write clears them. When both name the same channel in one cycle, the channel ends up disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eoc_valid | input | 1 | Conversion-complete event |
| eoc_chan | input | 3 | Channel of the event |
| eoc_data | input | 10 | Result of the event |
| en_wr | input | 1 | Enable-mask write strobe |
| en_mask | input | 8 | Channels to enable |
| dis_wr | input | 1 | Disable-mask write strobe |
| dis_mask | input | 8 | Channels to disable |
| rd_valid | input | 1 | Read request |
| rd_sel | input | 2 | Read source: 0 status, 1 most-recent, 2 channel slot |
| rd_chan | input | 3 | Channel slot for rd_sel 2 |
| rd_ack | output | 1 | Read data valid (one cycle after rd_valid) |
| rd_data | output | 32 | Read data |

## Verification
A wrong flag is held in a register until a read clears it. The mistake therefore shows in the next status word read, one cycle after the read request, and it stays visible on every later status read until cleared. A wrong most-recent channel tag shows up differently. A most-recent read then clears the wrong pending bit, and that is visible in the status read that follows. A discarded conversion that wrongly leaks into storage changes a later slot read or most-recent read.

// File: rtl/adc_trk_pkg.sv
package adc_trk_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_LAST   = 2'd1,
    SEL_CHAN   = 2'd2
  } rd_sel_t;

  localparam int RD_W       = 32;
  localparam int LAST_CH_LSB = 12;
endpackage

// File: rtl/adc_trk_enable.sv
module adc_trk_enable #(
  parameter int NUM_CH = 8,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_wr,
  input  logic [NUM_CH-1:0] en_mask,
  input  logic              dis_wr,
  input  logic [NUM_CH-1:0] dis_mask,
  input  logic              eoc_valid,
  input  logic [CH_W-1:0]   eoc_chan,
  output logic [NUM_CH-1:0] hit,
  output logic              accept
);
  logic [NUM_CH-1:0] ch_en;
  logic [NUM_CH-1:0] dis_now;
  logic [NUM_CH-1:0] en_now;

  assign dis_now = dis_wr ? dis_mask : '0;
  assign en_now  = en_wr  ? en_mask  : '0;

  always_ff @(posedge clk) begin
    if (rst) ch_en <= '0;
    else     ch_en <= (ch_en | en_now) & ~dis_now;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_hit
      assign hit[g] = eoc_valid && (eoc_chan == CH_W'(g)) &&
                      ch_en[g] && !dis_now[g];
    end
  endgenerate

  assign accept = |hit;

  assert_single_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  assert_disable_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (dis_wr && en_wr && ((dis_mask & en_mask) != '0)) |=>
      ((ch_en & $past(dis_mask & en_mask)) == '0));
endmodule

// File: rtl/adc_trk_chan_flag.sv
module adc_trk_chan_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr_pend,
  input  logic stat_rd,
  output logic pend,
  output logic lost
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      lost <= 1'b0;
    end else begin
      pend <= hit | (pend & ~clr_pend);
      lost <= (hit & pend) | (lost & ~stat_rd);
    end
  end

  assert_overrun_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && pend) |=> lost);

  assert_status_clears_lost_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(hit && pend)) |=> !lost);

  assert_pend_needs_hit_R9: assert property (@(posedge clk) disable iff (rst)
    (!pend && !hit) |=> !pend);
endmodule

// File: rtl/adc_trk_global.sv
module adc_trk_global #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              clr_new,
  input  logic              stat_rd,
  input  logic [CH_W-1:0]   eoc_chan,
  input  logic [DATA_W-1:0] eoc_data,
  output logic              new_res,
  output logic              glost,
  output logic [CH_W-1:0]   last_chan,
  output logic [DATA_W-1:0] last_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      new_res   <= 1'b0;
      glost     <= 1'b0;
      last_chan <= '0;
      last_data <= '0;
    end else begin
      new_res <= accept | (new_res & ~clr_new);
      glost   <= (accept & new_res) | (glost & ~stat_rd);
      if (accept) begin
        last_chan <= eoc_chan;
        last_data <= eoc_data;
      end
    end
  end

  assert_new_on_accept_R7: assert property (@(posedge clk) disable iff (rst)
    accept |=> new_res);

  assert_glost_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (accept && new_res) |=> glost);

  assert_status_clears_glost_R6: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !(accept && new_res)) |=> !glost);

  assert_last_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> (last_chan == $past(eoc_chan) && last_data == $past(eoc_data)));
endmodule

// File: rtl/adc_trk_data_store.sv
module adc_trk_data_store #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CH_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [CH_W-1:0]   raddr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [NUM_CH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/adc_status_tracker.sv
module adc_status_tracker #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 10,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoc_valid,
  input  logic [CH_W-1:0]   eoc_chan,
  input  logic [DATA_W-1:0] eoc_data,
  input  logic              en_wr,
  input  logic [NUM_CH-1:0] en_mask,
  input  logic              dis_wr,
  input  logic [NUM_CH-1:0] dis_mask,
  input  logic              rd_valid,
  input  logic [1:0]        rd_sel,
  input  logic [CH_W-1:0]   rd_chan,
  output logic              rd_ack,
  output logic [31:0]       rd_data
);
  import adc_trk_pkg::*;

  rd_sel_t sel;
  assign sel = rd_sel_t'(rd_sel);

  logic [NUM_CH-1:0] hit;
  logic              accept;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] lost;
  logic [NUM_CH-1:0] clr_pend;
  logic              new_res;
  logic              glost;
  logic [CH_W-1:0]   last_chan;
  logic [DATA_W-1:0] last_data;
  logic [DATA_W-1:0] slot_q;
  logic              stat_rd;
  logic              last_rd;
  logic              chan_rd;

  assign stat_rd = rd_valid && (sel == SEL_STATUS);
  assign last_rd = rd_valid && (sel == SEL_LAST);
  assign chan_rd = rd_valid && (sel == SEL_CHAN);

  adc_trk_enable #(.NUM_CH(NUM_CH)) u_enable (
    .clk(clk), .rst(rst),
    .en_wr(en_wr), .en_mask(en_mask),
    .dis_wr(dis_wr), .dis_mask(dis_mask),
    .eoc_valid(eoc_valid), .eoc_chan(eoc_chan),
    .hit(hit), .accept(accept)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      assign clr_pend[g] = (chan_rd && rd_chan == CH_W'(g)) ||
                           (last_rd && last_chan == CH_W'(g));
      adc_trk_chan_flag u_flag (
        .clk(clk), .rst(rst),
        .hit(hit[g]), .clr_pend(clr_pend[g]), .stat_rd(stat_rd),
        .pend(pend[g]), .lost(lost[g])
      );
    end
  endgenerate

  adc_trk_global #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_global (
    .clk(clk), .rst(rst),
    .accept(accept), .clr_new(last_rd), .stat_rd(stat_rd),
    .eoc_chan(eoc_chan), .eoc_data(eoc_data),
    .new_res(new_res), .glost(glost),
    .last_chan(last_chan), .last_data(last_data)
  );

  adc_trk_data_store #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_store (
    .clk(clk),
    .we(accept), .waddr(eoc_chan), .wdata(eoc_data),
    .re(chan_rd), .raddr(rd_chan), .q(slot_q)
  );

  logic [RD_W-1:0] stat_word;
  logic [RD_W-1:0] last_word;

  always_comb begin
    stat_word = '0;
    stat_word[NUM_CH-1:0]        = pend;
    stat_word[2*NUM_CH-1:NUM_CH] = lost;
    stat_word[2*NUM_CH]          = new_res;
    stat_word[2*NUM_CH+1]        = glost;
    last_word = '0;
    last_word[DATA_W-1:0]                 = last_data;
    last_word[LAST_CH_LSB+CH_W-1:LAST_CH_LSB] = last_chan;
  end

  logic            slot_sel_q;
  logic [RD_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack     <= 1'b0;
      slot_sel_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      rd_ack <= rd_valid;
      if (rd_valid) begin
        slot_sel_q <= chan_rd;
        hold_q     <= last_rd ? last_word : stat_word;
      end
    end
  end

  assign rd_data = slot_sel_q ? {{(RD_W-DATA_W){1'b0}}, slot_q} : hold_q;

  assert_discard_keeps_last_R9: assert property (@(posedge clk) disable iff (rst)
    (eoc_valid && dis_wr && dis_mask[eoc_chan]) |=> $stable(last_data));

  assert_ack_follows_read_R2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_ack);
endmodule

// File: tb/test_adc_status_tracker.sv
`timescale 1ns/1ps
module test_adc_status_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eoc_valid = 1'b0;
  logic [2:0]  eoc_chan = '0;
  logic [9:0]  eoc_data = '0;
  logic        en_wr = 1'b0;
  logic [7:0]  en_mask = '0;
  logic        dis_wr = 1'b0;
  logic [7:0]  dis_mask = '0;
  logic        rd_valid = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [2:0]  rd_chan = '0;
  logic        rd_ack;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  adc_status_tracker i_adc_status_tracker (
    .clk(clk), .rst(rst),
    .eoc_valid(eoc_valid), .eoc_chan(eoc_chan), .eoc_data(eoc_data),
    .en_wr(en_wr), .en_mask(en_mask), .dis_wr(dis_wr), .dis_mask(dis_mask),
    .rd_valid(rd_valid), .rd_sel(rd_sel), .rd_chan(rd_chan),
    .rd_ack(rd_ack), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic ev, input int ch, input int d,
                      input logic rv, input int sel, input int rch,
                      input logic [7:0] enm, input logic [7:0] dism,
                      output logic [31:0] q);
    eoc_valid = ev; eoc_chan = ch[2:0]; eoc_data = d[9:0];
    rd_valid = rv; rd_sel = sel[1:0]; rd_chan = rch[2:0];
    en_wr = |enm; en_mask = enm; dis_wr = |dism; dis_mask = dism;
    @(posedge clk);
    @(negedge clk);
    eoc_valid = 0; rd_valid = 0; en_wr = 0; dis_wr = 0;
    en_mask = '0; dis_mask = '0;
    q = rd_data;
    if (rv) chk("R2 rd_ack", {31'b0, rd_ack}, 32'd1);
  endtask

  task automatic conv(input int ch, input int d);
    logic [31:0] q;
    step(1, ch, d, 0, 0, 0, 8'h00, 8'h00, q);
  endtask

  task automatic rstat(input logic [31:0] exp, input string tag);
    logic [31:0] q;
    step(0, 0, 0, 1, 0, 0, 8'h00, 8'h00, q);
    chk({tag, " status"}, q, exp);
  endtask

  task automatic rlast(input logic [31:0] exp, input string tag);
    logic [31:0] q;
    step(0, 0, 0, 1, 1, 0, 8'h00, 8'h00, q);
    chk({tag, " last"}, q, exp);
  endtask

  task automatic rchan(input int ch, input logic [31:0] exp, input string tag);
    logic [31:0] q;
    step(0, 0, 0, 1, 2, ch, 8'h00, 8'h00, q);
    chk({tag, " slot"}, q, exp);
  endtask

  task automatic t_reset;
    chk("R1 rd_ack", {31'b0, rd_ack}, 32'd0);
    rstat(32'h0, "R1");
    rlast(32'h0, "R1");
    conv(0, 10'h3FF);
    rstat(32'h0, "R1 disabled");
    rlast(32'h0, "R1 disabled");
  endtask

  task automatic t_basic;
    logic [31:0] q;
    step(0, 0, 0, 0, 0, 0, 8'hFF, 8'h00, q);
    conv(3, 10'h155);
    rstat(32'h0001_0008, "R2");
    rchan(3, 32'h155, "R2");
    rstat(32'h0001_0000, "R3");
    rlast(32'h3155, "R2");
    rstat(32'h0, "R7");
  endtask

  task automatic t_last_clear;
    conv(1, 10'h011);
    conv(2, 10'h022);
    rstat(32'h0003_0006, "R5");
    rstat(32'h0001_0006, "R6");
    rlast(32'h2022, "R2");
    rstat(32'h0000_0002, "R3");
    rchan(1, 32'h011, "R3");
    rstat(32'h0, "R3");
  endtask

  task automatic t_overrun;
    logic [31:0] q;
    conv(4, 10'h100);
    conv(4, 10'h101);
    rstat(32'h0003_1010, "R4");
    rstat(32'h0001_0010, "R6");
    step(1, 4, 10'h102, 1, 2, 4, 8'h00, 8'h00, q);
    chk("R2 read-first slot", q, 32'h101);
    rstat(32'h0003_1010, "R4 same-cycle read");
    rlast(32'h4102, "R4");
    rstat(32'h0, "R4");
  endtask

  task automatic t_status_collide;
    logic [31:0] q;
    conv(5, 10'h055);
    conv(5, 10'h056);
    step(1, 5, 10'h057, 1, 0, 0, 8'h00, 8'h00, q);
    chk("R6 pre-update status", q, 32'h0003_2020);
    rstat(32'h0003_2020, "R6 collide sets again");
    rchan(5, 32'h057, "R6");
    conv(5, 10'h058);
    conv(5, 10'h059);
    rchan(5, 32'h059, "R6");
    step(1, 5, 10'h05A, 1, 0, 0, 8'h00, 8'h00, q);
    chk("R6 lost-without-pending", q, 32'h0003_2000);
    rstat(32'h0003_0020, "R6 lost reset");
    rlast(32'h505A, "R6");
    rstat(32'h0, "R6");
  endtask

  task automatic t_new_priority;
    logic [31:0] q;
    conv(6, 10'h066);
    step(1, 6, 10'h067, 1, 1, 0, 8'h00, 8'h00, q);
    chk("R7 last read-first", q, 32'h6066);
    rstat(32'h0003_4040, "R7 new kept");
    rlast(32'h6067, "R7");
    rstat(32'h0, "R7");
  endtask

  task automatic t_glost_slot_read;
    logic [31:0] q;
    conv(1, 10'h0C1);
    step(1, 1, 10'h0C2, 1, 2, 3, 8'h00, 8'h00, q);
    chk("R5 other slot", q, 32'h155);
    rstat(32'h0003_0202, "R5 slot read");
    rlast(32'h10C2, "R5");
    rstat(32'h0, "R5");
  endtask

  task automatic t_disable_other;
    logic [31:0] q;
    conv(1, 10'h0A1);
    step(1, 0, 10'h0B0, 0, 0, 0, 8'h00, 8'h04, q);
    rstat(32'h0003_0003, "R8");
    rchan(0, 32'h0B0, "R8");
    rlast(32'h00B0, "R8");
    rchan(1, 32'h0A1, "R8");
    rstat(32'h0, "R8");
  endtask

  task automatic t_discard;
    logic [31:0] q;
    conv(2, 10'h3FF);
    rstat(32'h0, "R9");
    rlast(32'h00B0, "R9");
    rchan(2, 32'h022, "R9");
    step(1, 3, 10'h2AA, 1, 2, 3, 8'h00, 8'h08, q);
    chk("R9 slot read", q, 32'h155);
    rstat(32'h0, "R9 same-cycle disable");
    rchan(3, 32'h155, "R9 same-cycle disable");
  endtask

  task automatic t_enable;
    logic [31:0] q;
    step(0, 0, 0, 0, 0, 0, 8'h04, 8'h04, q);
    conv(2, 10'h012);
    rstat(32'h0, "R10 disable wins");
    step(0, 0, 0, 0, 0, 0, 8'h04, 8'h00, q);
    conv(2, 10'h013);
    rstat(32'h0001_0004, "R10 enabled");
    rchan(2, 32'h013, "R10");
    rlast(32'h2013, "R10");
    rstat(32'h0, "R10");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_basic;
    t_last_clear;
    t_overrun;
    t_status_collide;
    t_new_priority;
    t_glost_slot_read;
    t_disable_other;
    t_discard;
    t_enable;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule